// File: doc/BRIEF.md
# UART Baud Tick Generator

This block makes the 16x oversampling enable for a serial port. Software loads a 16-bit divisor as two bytes through a small register interface. The divisor bytes can only be reached while the divisor-access bit of the control byte is set. The tick counter stays idle after reset. It starts when software clears the divisor-access bit after having set it.

Once started, the generator emits a one-cycle `tick` every N system clocks, where N is the divisor, and raises `running`. Only a master reset stops it again. Software may reopen divisor access while the generator runs and write new bytes. Such a change takes hold at the next counter reload, and the generator is not restarted.

Register map (2-bit `addr`): 0 = divisor low byte, 1 = divisor high byte, 2 = control byte (bit 7 is divisor access), 3 = unused and reads 0. Reads are combinational on `addr` and are zero-extended to 16 bits.

Top module: `baud_tick_gen`

## Requirements
- R1: While control bit 7 is 1, writes to address 0 and address 1 load the low and high divisor bytes, and reads of those addresses return the stored byte.
- R2: While control bit 7 is 0, writes to address 0 and address 1 are ignored, and reads of those addresses return 0.
- R3: After reset the generator is stopped: `tick` and `running` are 0, and all registers read 0.
- R4: A write that changes control bit 7 from 1 to 0 starts the generator. The first `tick` is seen N clocks after the clock edge that takes that write. Setting the bit, or writing 0 while it is already 0, does not start the generator.
- R5: Once started, the generator keeps running whatever is later written to the control byte. Only reset stops it.
- R6: The control byte reads back in bits 7:0 as written, and bits 15:8 read 0. Address 3 reads 0.
- R7: While running, `tick` is high for one clock out of every N, with N = {high byte, low byte}.
- R8: A divisor of 0 behaves as 1, so `tick` is high on every clock.
- R9: A divisor changed while running takes effect from the next reload, which happens at the next `tick`.
- R10: `running` is 1 exactly when the generator has started since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 16 | Read data, combinational on `addr` |
| tick | output | 1 | One-cycle 16x oversampling enable |
| running | output | 1 | Generator has started since reset |

## Verification
The divisor is tried with 1, 2, 3, 5, 16, 300 and 0. Each value is loaded and started from a fresh reset. The start latency and two periods are measured for each. Measuring both separates an off-by-one in the reload from an off-by-one in the start load, and the 0 and 1 cases separate the zero clamp from ordinary counting. Directed sequences cover the following:
- writes made with divisor access closed, then read back after access is reopened;
- setting the access bit without clearing it;
- toggling the access bit while running;
- changing the divisor mid-run, which shows whether the new value waits for the next reload.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int BUS_W  = 16;
  localparam int ACC_BIT = 7;

  typedef enum logic [1:0] {
    A_DIV_LO = 2'd0,
    A_DIV_HI = 2'd1,
    A_CTRL   = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  // Divisor actually used for counting: zero is clamped to one.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
  endfunction

  // Value loaded into the down-counter so that a tick recurs every eff_div clocks.
  function automatic logic [DIV_W-1:0] reload_val(input logic [DIV_W-1:0] d);
    return eff_div(d) - {{(DIV_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic [DIV_W-1:0] divisor,
  output logic             acc_open
);
  logic [BYTE_W-1:0] ctrl_q, lo_q, hi_q;
  logic wr_ctrl, wr_lo, wr_hi;

  assign acc_open = ctrl_q[ACC_BIT];
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_lo    = wr_en && (addr == A_DIV_LO) && acc_open;
  assign wr_hi    = wr_en && (addr == A_DIV_HI) && acc_open;
  assign divisor  = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_lo)   lo_q   <= wr_data;
      if (wr_hi)   hi_q   <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_DIV_LO: if (acc_open) rd_data[BYTE_W-1:0] = lo_q;
      A_DIV_HI: if (acc_open) rd_data[BYTE_W-1:0] = hi_q;
      A_CTRL:   rd_data[BYTE_W-1:0] = ctrl_q;
      default:  rd_data = '0;
    endcase
  end

  // R2: closed access leaves divisor bytes untouched
  a_r2_gated_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_open && wr_en && addr == A_DIV_LO) |=> $stable(lo_q));
  a_r2_gated_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_open && wr_en && addr == A_DIV_HI) |=> $stable(hi_q));
  // R6: upper read bits of the control byte are zero
  a_r6_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rd_data[BUS_W-1:BYTE_W] == '0));
endmodule

// File: rtl/baud_start_det.sv
module baud_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_open,
  output logic start_evt,
  output logic running
);
  logic acc_prev;

  assign start_evt = acc_prev && !acc_open && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_prev <= 1'b0;
      running  <= 1'b0;
    end else begin
      acc_prev <= acc_open;
      if (start_evt) running <= 1'b1;
    end
  end

  // R5: once set, running only clears through reset
  a_r5_sticky_running: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

// File: rtl/baud_tick_cnt.sv
module baud_tick_cnt
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             running,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick    = running && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || tick) begin
      cnt_q <= reload_val(divisor);
    end else if (running) begin
      cnt_q <= cnt_q - {{(DIV_W-1){1'b0}}, 1'b1};
    end
  end

  // R3: no tick while idle
  a_r3_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick);
  // R7: tick lasts a single clock unless the divisor is one
  a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_div(divisor) != 1) |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wr_data,
  output logic [15:0] rd_data,
  output logic        tick,
  output logic        running
);
  logic [DIV_W-1:0] divisor;
  logic             acc_open;
  logic             start_evt;

  baud_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .divisor(divisor), .acc_open(acc_open)
  );

  baud_start_det u_start (
    .clk(clk), .rst_n(rst_n), .acc_open(acc_open),
    .start_evt(start_evt), .running(running)
  );

  baud_tick_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .running(running),
    .divisor(divisor), .tick(tick)
  );

  // R4: running rises only after divisor access was closed
  a_r4_start_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !$past(acc_open));
  // R10: running never rises while access is open
  a_r10_no_start_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && acc_open) |=> !running);
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [15:0] rd_data;
  logic tick, running;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .running(running)
  );

  localparam int NV = 7;
  localparam logic [15:0] DIVS [NV] = '{16'd1, 16'd2, 16'd3, 16'd5, 16'd16, 16'd300, 16'd0};

  function automatic int period_of(input logic [15:0] d);
    return (d == 16'd0) ? 1 : int'(d);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // Returns 1 ns after the edge that takes the write
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a; #1;
    v = int'(rd_data);
  endtask

  task automatic load_div(input logic [15:0] d);
    wr(2'd2, 8'h80);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
  endtask

  // Edges until tick is seen, counted from the current point; limit guards hangs
  task automatic edges_to_tick(input int limit, output int n);
    n = -1;
    for (int j = 1; j <= limit; j++) begin
      @(posedge clk); #1;
      if (tick) begin n = j; break; end
    end
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int j = 0; j < cycles; j++) begin
      @(posedge clk); #1;
      if (tick) n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int v, lat, p1, p2, nt;
    do_reset();

    // R3 reset state
    check("R3 tick", int'(tick), 0);
    check("R3 running", int'(running), 0);
    rd(2'd2, v); check("R3 ctrl", v, 0);
    rd(2'd3, v); check("R6 unused addr", v, 0);

    // Vector table walk: R4 latency, R7 period, R8 zero clamp, R10 running
    for (int i = 0; i < NV; i++) begin
      do_reset();
      load_div(DIVS[i]);
      rd(2'd0, v); check("R1 lo readback", v, int'(DIVS[i][7:0]));
      rd(2'd1, v); check("R1 hi readback", v, int'(DIVS[i][15:8]));
      check("R10 not yet running", int'(running), 0);
      wr(2'd2, 8'h00);
      edges_to_tick(1000, lat);
      check(DIVS[i] == 0 ? "R8 first tick" : "R4 first tick latency", lat, period_of(DIVS[i]));
      check("R10 running", int'(running), 1);
      edges_to_tick(1000, p1);
      edges_to_tick(1000, p2);
      check(DIVS[i] == 0 ? "R8 period" : "R7 period", p1, period_of(DIVS[i]));
      check("R7 period again", p2, period_of(DIVS[i]));
    end

    // R2: writes ignored with access closed; reads return 0
    do_reset();
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hA5);
    rd(2'd0, v); check("R2 closed read lo", v, 0);
    wr(2'd2, 8'h80);
    rd(2'd0, v); check("R2 ignored write lo", v, 0);
    rd(2'd1, v); check("R2 ignored write hi", v, 0);

    // R6 control readback with upper bits zero
    wr(2'd2, 8'hBF);
    rd(2'd2, v); check("R6 ctrl readback", v, 32'h00BF);

    // R4: setting access alone does not start; writing 0 while 0 does not start
    do_reset();
    wr(2'd2, 8'h00);
    count_ticks(40, nt); check("R4 no start on 0->0", nt, 0);
    check("R4 running after 0->0", int'(running), 0);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'd4);
    count_ticks(40, nt); check("R4 no start while open", nt, 0);
    check("R4 running while open", int'(running), 0);

    // R9 and R5: start at 4, change to 7 while running, toggle access
    wr(2'd2, 8'h00);
    edges_to_tick(100, lat); check("R4 start latency 4", lat, 4);
    edges_to_tick(100, p1); check("R7 period 4", p1, 4);
    wr(2'd2, 8'h80);
    check("R5 running with access open", int'(running), 1);
    wr(2'd0, 8'd7);
    wr(2'd2, 8'h00);
    check("R5 running after re-close", int'(running), 1);
    // The pending interval may still be the old one; the next full one uses 7
    edges_to_tick(100, p1);
    check("R9 interval before reload", (p1 <= 4) ? 1 : 0, 1);
    edges_to_tick(100, p2); check("R9 new period after reload", p2, 7);
    edges_to_tick(100, p2); check("R5 period kept", p2, 7);

    // R5: only reset stops it
    do_reset();
    check("R5 running cleared by reset", int'(running), 0);
    count_ticks(30, nt); check("R3 no ticks after reset", nt, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule